// File: doc/BRIEF.md
# Timed-Unlock Clock Control Register

This block is a byte-wide control and status register for clock selection. A guard keeps the clock command from being changed by accident. Software opens a short write window by writing a key byte, which sets the change-enable bit with every other bit at zero. While the window is open, one write loads a new 4-bit clock command. That command goes to the clock-availability logic, together with a one-cycle valid strobe.

The register also shows a clock-ready flag. The flag clears when a new command is accepted. It sets again only after the availability logic's stable input has been synchronised and seen low and then high again. The start-up delay of an oscillator is therefore allowed to vary.

The design has two state machines. The unlock machine has the states LOCKED and OPEN:
- LOCKED goes to OPEN on a key write.
- OPEN goes back to LOCKED on an accepted command write.
- OPEN also goes back to LOCKED on timeout, when its down-counter reaches zero.

The ready machine has the states WAIT_RISE, WAIT_DROP and SET:
- Any state goes to WAIT_DROP on a request.
- WAIT_DROP goes to WAIT_RISE when the synchronised level is low.
- WAIT_RISE goes to SET when the level is high.
- SET goes to WAIT_RISE when the level is low.

Top module: `clkctl_guard`

## Requirements
- R1: After reset, the register reads 0x00, `cmd_valid` is 0 and `cmd_code` is 0.
- R2: Bit 7 (change-enable) sets only on a selected write of exactly 0x80. Any other write while locked leaves bit 7 at 0.
- R3: After a key write, bit 7 reads 1 for exactly 4 cycles and then clears by itself.
- R4: While bit 7 is 1, a selected write of any value other than 0x80 is a command write. It loads bits 3:0 of the write data into bits 3:0 of the register and clears bit 7 at the same edge.
- R5: A write of 0x80 while the window is open neither restarts nor shortens the 4-cycle window.
- R6: A command write while bit 7 is 0 is ignored, and the previous command is kept.
- R7: Bits 6:5 always read 0, whatever is written to them.
- R8: An accepted command write gives `cmd_valid` high for exactly one cycle, with `cmd_code` equal to the new command. `cmd_code` keeps its value at all other times.
- R9: Bit 4 (clock ready) cannot be written from the bus. It clears at the edge where a command is accepted, and stays 0 until the stable input has been seen low.
- R10: Bit 4 sets on the third clock edge after `avail_stable` rises (2-stage synchroniser). It returns to 0 after `avail_stable` falls.
- R11: When `bus_sel` is 0, `bus_rdata` is 0x00 and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data {enable, 0, 0, ready, command} |
| avail_stable | input | 1 | Asynchronous clock-stable level from the availability logic |
| cmd_valid | output | 1 | One-cycle strobe for a new command |
| cmd_code | output | 4 | Current clock command |

## Verification
The bench targets these corner cases:
- Window length. An off-by-one counter would show bit 7 for 3 or 5 cycles.
- A key rewrite in mid-window. A naive design would restart the count or treat the rewrite as a command of zero.
- Writes with non-zero data while locked, including a write of 0x8F. A loose key compare would open the window or load a command.
- Writes that set the reserved bits. These must not read back.
- The ready handshake, which is sampled at the exact cycle set by the synchroniser depth. A design that lets the flag follow a still-high input right after a request would never show the flag dropping.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned CMD_W    = 4;
    localparam int unsigned EN_BIT   = 7;
    localparam int unsigned RDY_BIT  = 4;
    localparam logic [REG_W-1:0] KEY_BYTE = 8'h80;

    typedef enum logic {
        ULK_LOCKED,
        ULK_OPEN
    } ulk_state_e;

    typedef enum logic [1:0] {
        RDY_WAIT_RISE,
        RDY_WAIT_DROP,
        RDY_SET
    } rdy_state_e;

endpackage

// File: rtl/clkctl_unlock.sv
module clkctl_unlock
    import clkctl_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wdata,
    output logic             en_o,
    output logic             accept_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic             cmd_valid_o
);

    localparam int unsigned CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam int unsigned RW = CW + 2;

    ulk_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          key_hit, cmd_hit;
    logic [CMD_W-1:0] cmd_q;
    logic          valid_q;

    always_comb begin
        key_hit = wr_stb && (wdata == KEY_BYTE);
        cmd_hit = wr_stb && (wdata != KEY_BYTE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ULK_LOCKED: begin
                if (key_hit) begin
                    state_d = ULK_OPEN;
                    cnt_d   = CW'(WIN_CYCLES - 1);
                end
            end
            ULK_OPEN: begin
                if (cmd_hit) begin
                    state_d = ULK_LOCKED;
                    cnt_d   = '0;
                end else if (cnt_q == '0) begin
                    state_d = ULK_LOCKED;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ULK_LOCKED;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ULK_LOCKED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        en_o     = (state_q == ULK_OPEN);
        accept_o = (state_q == ULK_OPEN) && cmd_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= accept_o;
            if (accept_o) cmd_q <= wdata[CMD_W-1:0];
        end
    end

    assign cmd_o       = cmd_q;
    assign cmd_valid_o = valid_q;

    // checking support: length of the current open run
    logic [RW-1:0] open_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    open_run_q <= '0;
        else if (en_o) open_run_q <= open_run_q + 1'b1;
        else           open_run_q <= '0;
    end

    a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> $past(wr_stb && wdata == KEY_BYTE));

    a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        open_run_q <= RW'(WIN_CYCLES));

    a_r3_window_exact: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(en_o) && !$past(accept_o)) |-> open_run_q == RW'(WIN_CYCLES));

    a_r4_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !en_o);

    a_r5_rewrite_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && key_hit && cnt_q != '0) |=> en_o);

    a_r8_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_o |-> $stable(cmd_o));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

endmodule

// File: rtl/clkctl_ready.sv
module clkctl_ready
    import clkctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic avail_async,
    input  logic req_i,
    output logic ready_o
);

    logic       lvl;
    rdy_state_e state_q, state_d;

    generate
        if (SYNC_STAGES <= 1) begin : g_sync1
            logic s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= avail_async;
            end
            assign lvl = s_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= {s_q[SYNC_STAGES-2:0], avail_async};
            end
            assign lvl = s_q[SYNC_STAGES-1];
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (req_i) begin
            state_d = RDY_WAIT_DROP;
        end else begin
            unique case (state_q)
                RDY_WAIT_RISE: if (lvl)  state_d = RDY_SET;
                RDY_WAIT_DROP: if (!lvl) state_d = RDY_WAIT_RISE;
                RDY_SET:       if (!lvl) state_d = RDY_WAIT_RISE;
                default:                 state_d = RDY_WAIT_RISE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RDY_WAIT_RISE;
        else        state_q <= state_d;
    end

    always_comb ready_o = (state_q == RDY_SET);

    a_r9_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> !ready_o);

    a_r10_rise_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(lvl));

    a_r10_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && !req_i) |=> !ready_o);

endmodule

// File: rtl/clkctl_guard.sv
module clkctl_guard
    import clkctl_pkg::*;
#(
    parameter int unsigned WIN_CYCLES  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             avail_stable,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_code
);

    logic wr_stb;
    logic en, accept, ready;

    assign wr_stb = bus_sel && bus_wr;

    clkctl_unlock #(.WIN_CYCLES(WIN_CYCLES)) u_unlock (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wdata       (bus_wdata),
        .en_o        (en),
        .accept_o    (accept),
        .cmd_o       (cmd_code),
        .cmd_valid_o (cmd_valid)
    );

    clkctl_ready #(.SYNC_STAGES(SYNC_STAGES)) u_ready (
        .clk         (clk),
        .rst_n       (rst_n),
        .avail_async (avail_stable),
        .req_i       (accept),
        .ready_o     (ready)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            bus_rdata[EN_BIT]      = en;
            bus_rdata[RDY_BIT]     = ready;
            bus_rdata[CMD_W-1:0]   = cmd_code;
        end
    end

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[6:5] == 2'b00);

    a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> bus_rdata == '0);

endmodule

// File: tb/clkctl_guard_bench.sv
module clkctl_guard_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       avail_stable = 1'b0;
    logic       cmd_valid;
    logic [3:0] cmd_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clkctl_guard u_clkctl_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .avail_stable (avail_stable),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code)
    );

    // {sel, wr, wdata, expected read after the edge}, avail_stable low
    localparam logic [17:0] VEC [0:19] = '{
        {1'b1, 1'b1, 8'h8F, 8'h00},  // R2 not the key
        {1'b1, 1'b1, 8'h80, 8'h80},  // R2 key opens
        {1'b0, 1'b0, 8'h00, 8'h80},  // R3 open 2
        {1'b1, 1'b1, 8'h80, 8'h80},  // R5 rewrite, open 3
        {1'b0, 1'b0, 8'h00, 8'h80},  // R5 open 4, not extended
        {1'b0, 1'b0, 8'h00, 8'h00},  // R3 closed after 4
        {1'b1, 1'b1, 8'h05, 8'h00},  // R6 locked write ignored
        {1'b1, 1'b1, 8'h80, 8'h80},  // R2 reopen
        {1'b1, 1'b1, 8'h65, 8'h05},  // R4 R7 command loaded, reserved dropped
        {1'b0, 1'b0, 8'h00, 8'h05},  // R4 stays closed
        {1'b1, 1'b1, 8'h0A, 8'h05},  // R6 kept
        {1'b1, 1'b1, 8'h80, 8'h85},  // R3 open 1
        {1'b0, 1'b0, 8'h00, 8'h85},  // R3 open 2
        {1'b0, 1'b0, 8'h00, 8'h85},  // R3 open 3
        {1'b0, 1'b0, 8'h00, 8'h85},  // R3 open 4
        {1'b0, 1'b0, 8'h00, 8'h05},  // R3 timeout
        {1'b1, 1'b1, 8'h80, 8'h85},  // R2 open
        {1'b1, 1'b1, 8'hE3, 8'h03},  // R4 R7 bit7 plus command accepted
        {1'b1, 1'b1, 8'h10, 8'h03},  // R9 ready not writable
        {1'b0, 1'b1, 8'h80, 8'h03}   // R11 unselected write ignored
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic w, input logic [7:0] d);
        bus_sel = s; bus_wr = w; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_wdata = 8'h00;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        bus_sel = 1'b1;
        #1;
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 cmd_valid", {7'd0, cmd_valid}, 8'h00);
        check("R1 cmd_code", {4'd0, cmd_code}, 8'h00);
        bus_sel = 1'b0; #1;
        check("R11 unselected read", bus_rdata, 8'h00);

        for (int i = 0; i < 20; i++) begin
            step(VEC[i][17], VEC[i][16], VEC[i][15:8]);
            check($sformatf("vector %0d", i), bus_rdata, VEC[i][7:0]);
        end

        // R8 strobe: one cycle, with the new code
        step(1'b1, 1'b1, 8'h80);
        step(1'b1, 1'b1, 8'h09);
        check("R8 valid high", {7'd0, cmd_valid}, 8'h01);
        check("R8 code", {4'd0, cmd_code}, 8'h09);
        idle(1);
        check("R8 valid one cycle", {7'd0, cmd_valid}, 8'h00);
        check("R8 code held", {4'd0, cmd_code}, 8'h09);

        // R10 synchroniser latency
        avail_stable = 1'b1;
        idle(2);
        check("R10 not yet ready", bus_rdata & 8'h10, 8'h00);
        idle(1);
        check("R10 ready after 3 edges", bus_rdata & 8'h10, 8'h10);
        step(1'b1, 1'b1, 8'h00);
        check("R9 bus write ignored", bus_rdata & 8'h10, 8'h10);

        // R9 request clears and holds while input still high
        step(1'b1, 1'b1, 8'h80);
        step(1'b1, 1'b1, 8'h02);
        check("R9 cleared on request", bus_rdata, 8'h02);
        idle(5);
        check("R9 held clear until drop", bus_rdata & 8'h10, 8'h00);
        avail_stable = 1'b0;
        idle(4);
        avail_stable = 1'b1;
        idle(3);
        check("R10 ready again", bus_rdata & 8'h10, 8'h10);
        avail_stable = 1'b0;
        idle(3);
        check("R10 follows low level", bus_rdata & 8'h10, 8'h00);

        // R1 reset in mid-window
        step(1'b1, 1'b1, 8'h80);
        rst_n = 1'b0; #1;
        check("R1 reset clears", bus_rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        check("R1 locked after reset", bus_rdata, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule